// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the control-register end of a three-wire host bus. It has an active-low select, a serial clock and one shared data line. The shared line is split into a data input, a data output and an output enable, and the pad outside the block joins them. The block decodes each frame into a write or a read of a small register file. The register fields drive the rest of the chip directly: regulator state, filter bandwidth, local-oscillator choice, power mode, gain-loop timing and step size, demodulator band, and the calibration trigger.

The whole block runs on the system clock. The select, serial clock and data inputs first pass through a parameterised synchroniser, and the block then finds serial-clock edges by comparing the synchronised clock with its previous value. A frame is 16 serial-clock periods long: a direction bit, a 6-bit address sent MSB first, one spacer slot, and an 8-bit data field sent MSB first. A write takes effect only when the last bit arrives. A read returns the addressed byte on the same line, driven on falling edges, once the 7-bit header is complete. A write of a fixed key value to the command address returns every register to its initial state, with the power mode set to off.

Top module: `serctl_regs`

## Requirements
- R1: After reset, control word A (address 0x01) is 0x85 and control word B (address 0x02) is 0x04, and sdo_oe_o is low.
- R2: A frame is sampled on serial-clock rising edges while csn_i is low. It consists of a direction bit (0 = write, 1 = read), address bits 5..0, one spacer slot whose value is ignored, and data bits 7..0.
- R3: A write frame updates the addressed register on its 16th rising edge, and the new fields appear on the outputs no more than SYNC_STAGES+1 clock cycles after that edge.
- R4: If csn_i rises before the 16th rising edge of a write frame, no register changes.
- R5: While csn_i stays low, write frames may follow one another without gaps, and each one commits.
- R6: In a read frame, the header is taken on rising edges 1 to 7. Data bits 7..0 are driven on the falling edges that follow rising edges 8 to 15. The output is released on the falling edge after rising edge 16, or when csn_i goes high. sdo_oe_o is low at every other time.
- R7: After a read, any further serial-clock activity in the same select window is ignored: no register changes and the output stays released.
- R8: Writing 0xAA to address 0x03 sets control word A to 0x84 (power mode 00) and control word B to 0x04. Any other value written to address 0x03 has no effect.
- R9: Address 0x03 reads back 0x00. Writes to addresses other than 0x01 to 0x03 are ignored, and reads of those addresses return 0x00.
- R10: Bits 7, 6 and 3 of control word B always read 0, whatever value is written.
- R11: A low level on rst_ni restores the R1 values at once, without waiting for a clock edge.
- R12: Field map, word A: bit 7 ldo_stat_o, bit 6 ldo_on_o, bits 5:4 bpf_bw_o, bits 3:2 lo_sel_o, bits 1:0 pwr_mode_o. Word B: bits 5:4 agc_time_o, bit 2 agc_step_o, bit 1 band_o, bit 0 cal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Bus select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Data line, input side |
| sdo_o | output | 1 | Data line, output side |
| sdo_oe_o | output | 1 | Data line output enable |
| ldo_stat_o | output | 1 | Regulator output state |
| ldo_on_o | output | 1 | Regulator power control |
| bpf_bw_o | output | 2 | Band-pass filter width code |
| lo_sel_o | output | 2 | Local oscillator select |
| pwr_mode_o | output | 2 | Power mode |
| agc_time_o | output | 2 | Gain loop response time |
| agc_step_o | output | 1 | Gain step size |
| band_o | output | 1 | Demodulator band |
| cal_o | output | 1 | Calibration trigger |

## Verification
Every serial-clock or select change reaches the outputs SYNC_STAGES+1 system cycles later: a write's fields follow the 16th rising edge by that amount, and a read bit follows its falling edge by the same amount. The bench holds each serial-clock half period for 8 system cycles. It samples the read line and the fields only at the end of a half period, so each result has had at least 5 spare cycles to settle. A per-clock monitor compares the fields and the output enable with the bench model once select has been high for 6 cycles.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int          ADR_CTRL_A = 1;
  localparam int          ADR_CTRL_B = 2;
  localparam int          ADR_CMD    = 3;
  localparam logic [7:0]  RST_CTRL_A = 8'h85;
  localparam logic [7:0]  RST_CTRL_B = 8'h04;
  localparam logic [7:0]  SRST_CTRL_A = 8'h84;  // power mode cleared
  localparam logic [7:0]  MASK_CTRL_B = 8'h37;
  localparam logic [7:0]  CMD_KEY    = 8'hAA;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_ff
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ff <= {STAGES{RST_VAL}};
        end else begin
          ff[0] <= d_i;
          for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
        end
      end
      assign q_o = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int HDR_LEN = 1 + ADDR_W;
  localparam int FRM_LEN = HDR_LEN + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRM_LEN + 1);

  logic                 sclk_d;
  logic [CNT_W-1:0]     cnt;
  logic [FRM_LEN-2:0]   shreg;
  logic                 rd_mode;
  logic [DATA_W-1:0]    rd_sh;
  logic                 sdo_q, oe_q;
  logic                 rise, fall, rd_req;
  logic [FRM_LEN-1:0]   frame_w;
  logic [HDR_LEN-1:0]   hdr_w;

  assign rise    = sclk_s_i & ~sclk_d & ~csn_s_i;
  assign fall    = ~sclk_s_i & sclk_d & ~csn_s_i;
  assign frame_w = {shreg, sdi_s_i};
  assign hdr_w   = frame_w[HDR_LEN-1:0];

  assign wr_en_o   = rise & ~rd_mode & (cnt == CNT_W'(FRM_LEN-1)) & ~frame_w[FRM_LEN-1];
  assign wr_addr_o = frame_w[FRM_LEN-2 -: ADDR_W];
  assign wr_data_o = frame_w[DATA_W-1:0];
  assign rd_req    = rise & ~rd_mode & (cnt == CNT_W'(HDR_LEN-1)) & hdr_w[HDR_LEN-1];
  assign rd_addr_o = hdr_w[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      rd_sh   <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (csn_s_i) begin
      cnt     <= '0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (rise) begin
        shreg <= frame_w[FRM_LEN-2:0];
        if (rd_mode) begin
          if (cnt != CNT_W'(FRM_LEN)) cnt <= cnt + 1'b1;  // saturate, window locked
        end else if (cnt == CNT_W'(FRM_LEN-1)) begin
          cnt <= '0;                                     // next frame back to back
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (rd_req) begin
          rd_mode <= 1'b1;
          rd_sh   <= rd_data_i;
        end
      end
      if (fall && rd_mode) begin
        if (cnt >= CNT_W'(HDR_LEN+1) && cnt <= CNT_W'(FRM_LEN-1)) begin
          oe_q  <= 1'b1;
          sdo_q <= rd_sh[DATA_W-1];
          rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end else begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
  import serctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o
);
  localparam logic [ADDR_W-1:0] A_A   = ADDR_W'(ADR_CTRL_A);
  localparam logic [ADDR_W-1:0] A_B   = ADDR_W'(ADR_CTRL_B);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADR_CMD);

  logic [DATA_W-1:0] ctrl_a, ctrl_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_a <= DATA_W'(RST_CTRL_A);
      ctrl_b <= DATA_W'(RST_CTRL_B);
    end else if (wr_en_i) begin
      if (wr_addr_i == A_A) begin
        ctrl_a <= wr_data_i;
      end else if (wr_addr_i == A_B) begin
        ctrl_b <= wr_data_i & DATA_W'(MASK_CTRL_B);
      end else if (wr_addr_i == A_CMD && wr_data_i == DATA_W'(CMD_KEY)) begin
        ctrl_a <= DATA_W'(SRST_CTRL_A);
        ctrl_b <= DATA_W'(RST_CTRL_B);
      end
    end
  end

  always_comb begin
    if (rd_addr_i == A_A)      rd_data_o = ctrl_a;
    else if (rd_addr_i == A_B) rd_data_o = ctrl_b;
    else                       rd_data_o = '0;  // command word and holes read zero
  end

  assign ctrl_a_o = ctrl_a;
  assign ctrl_b_o = ctrl_b;
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csn_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  output logic       ldo_stat_o,
  output logic       ldo_on_o,
  output logic [1:0] bpf_bw_o,
  output logic [1:0] lo_sel_o,
  output logic [1:0] pwr_mode_o,
  output logic [1:0] agc_time_o,
  output logic       agc_step_o,
  output logic       band_o,
  output logic       cal_o
);
  logic              csn_s, sclk_s, sdi_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [DATA_W-1:0] ctrl_a, ctrl_b;

  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(csn_i), .q_o(csn_s));
  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i), .q_o(sdi_s));

  serctl_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .csn_s_i(csn_s), .sclk_s_i(sclk_s), .sdi_s_i(sdi_s),
    .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  serctl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b));

  assign ldo_stat_o = ctrl_a[7];
  assign ldo_on_o   = ctrl_a[6];
  assign bpf_bw_o   = ctrl_a[5:4];
  assign lo_sel_o   = ctrl_a[3:2];
  assign pwr_mode_o = ctrl_a[1:0];
  assign agc_time_o = ctrl_b[5:4];
  assign agc_step_o = ctrl_b[2];
  assign band_o     = ctrl_b[1];
  assign cal_o      = ctrl_b[0];
endmodule

// File: rtl/serctl_regs_chk.sv
module serctl_regs_chk
  import serctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_s,
  input logic              sclk_s,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_a,
  input logic [DATA_W-1:0] ctrl_b,
  input logic              sdo_oe_o
);
  p_oe_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s && $past(csn_s) |-> !sdo_oe_o);

  p_oe_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> (!$past(sclk_s) && $past(sclk_s, 2)));

  p_wr_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (sclk_s && !$past(sclk_s) && !csn_s));

  p_hold_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(ctrl_a) && $stable(ctrl_b)));

  p_soft_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == ADDR_W'(ADR_CMD) && wr_data == DATA_W'(CMD_KEY))
    |=> (ctrl_a == DATA_W'(SRST_CTRL_A) && ctrl_b == DATA_W'(RST_CTRL_B)));

  p_rsv_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_b[7:6] == 2'b00 && !ctrl_b[3]);
endmodule

bind serctl_regs serctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_s(csn_s), .sclk_s(sclk_s),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .sdo_oe_o(sdo_oe_o));

// File: tb/serctl_regs_bench.sv
module serctl_regs_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csn_i = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0;
  logic sdo_o, sdo_oe_o, ldo_stat_o, ldo_on_o, agc_step_o, band_o, cal_o;
  logic [1:0] bpf_bw_o, lo_sel_o, pwr_mode_o, agc_time_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;
  logic [7:0] m_a = 8'h85, m_b = 8'h04;

  always #5 clk = ~clk;

  serctl_regs u_serctl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .ldo_stat_o(ldo_stat_o), .ldo_on_o(ldo_on_o),
    .bpf_bw_o(bpf_bw_o), .lo_sel_o(lo_sel_o), .pwr_mode_o(pwr_mode_o),
    .agc_time_o(agc_time_o), .agc_step_o(agc_step_o), .band_o(band_o), .cal_o(cal_o));

  function automatic logic [7:0] port_a();
    return {ldo_stat_o, ldo_on_o, bpf_bw_o, lo_sel_o, pwr_mode_o};
  endfunction
  function automatic logic [7:0] port_b();
    return {2'b00, agc_time_o, 1'b0, agc_step_o, band_o, cal_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_fields(input string tag);
    chk(port_a() == m_a, {tag, " word A"}, port_a(), m_a);
    chk(port_b() == m_b, {tag, " word B"}, port_b(), m_b);
  endtask

  // per-clock comparison against the model once select has been idle
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (!rst_ni || !csn_i) hi_cnt <= 0;
    else begin
      hi_cnt <= hi_cnt + 1;
      if (hi_cnt >= 6 && !done) begin
        chk(port_a() == m_a, "R3 idle word A", port_a(), m_a);
        chk(port_b() == m_b, "R3 idle word B", port_b(), m_b);
        chk(sdo_oe_o == 1'b0, "R6 idle output enable", sdo_oe_o, 0);
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [5:0] a);
    if (a == 6'd1) return m_a;
    if (a == 6'd2) return m_b;
    return 8'h00;
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (a == 6'd1) m_a = d;
    else if (a == 6'd2) m_b = d & 8'h37;
    else if (a == 6'd3 && d == 8'hAA) begin m_a = 8'h84; m_b = 8'h04; end
  endtask

  task automatic cs_low();  csn_i = 1'b0; tick(HALF); endtask
  task automatic cs_high(); csn_i = 1'b1; tick(HALF); endtask

  // mode 0: plain, 1: check read data, 2: output must stay released
  task automatic run_frame(input logic rw, input logic [5:0] a, input logic [7:0] d,
                           input int nbits, input logic [7:0] exp, input int mode,
                           input string tag);
    logic [15:0] f;
    f = {rw, a, 1'b0, d};
    for (int k = 1; k <= nbits; k++) begin
      sdi_i = f[16-k];
      tick(HALF);
      if (mode == 1 && k <= 8) chk(sdo_oe_o == 1'b0, {tag, " enable before data"}, sdo_oe_o, 0);
      if (mode == 1 && k >= 9) begin
        chk(sdo_oe_o == 1'b1, {tag, " enable during data"}, sdo_oe_o, 1);
        chk(sdo_o == exp[16-k], {tag, " data bit"}, sdo_o, exp[16-k]);
      end
      if (mode == 2) chk(sdo_oe_o == 1'b0, {tag, " enable locked"}, sdo_oe_o, 0);
      sclk_i = 1'b1;
      tick(HALF);
      sclk_i = 1'b0;
    end
    sdi_i = 1'b0;
    tick(HALF);
    if (mode != 0) chk(sdo_oe_o == 1'b0, {tag, " released"}, sdo_oe_o, 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag);
    cs_low();
    run_frame(1'b0, a, d, 16, 8'h00, 0, tag);
    model_write(a, d);
    cs_high();
    check_fields(tag);
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    cs_low();
    run_frame(1'b1, a, 8'h00, 16, model_read(a), 1, tag);
    cs_high();
  endtask

  initial begin
    tick(3);
    // R1: reset values and idle line
    check_fields("R1 reset");
    chk(sdo_oe_o == 1'b0, "R1 enable", sdo_oe_o, 0);
    rst_ni = 1'b1;
    tick(10);
    check_fields("R1 after release");

    // R2 R3 R12: writes and field placement
    wr(6'd1, 8'h5A, "R2 write A");
    chk(bpf_bw_o == 2'b01 && lo_sel_o == 2'b10 && pwr_mode_o == 2'b10 && !ldo_stat_o && ldo_on_o,
        "R12 word A fields", port_a(), 8'h5A);
    wr(6'd2, 8'h25, "R3 write B");
    chk(agc_time_o == 2'b10 && agc_step_o && !band_o && cal_o, "R12 word B fields", port_b(), 8'h25);

    // R10: reserved bits of word B
    wr(6'd2, 8'hFF, "R10 reserved");
    rd(6'd2, "R10 readback");

    // R6: reads
    rd(6'd1, "R6 read A");
    wr(6'd1, 8'hA3, "R6 setup");
    rd(6'd1, "R6 read A again");

    // R9: command word and holes
    rd(6'd3, "R9 read command");
    rd(6'd0, "R9 read hole 0");
    rd(6'd63, "R9 read hole 63");
    wr(6'd16, 8'hFF, "R9 write hole");
    wr(6'd0, 8'h00, "R9 write hole 0");

    // R4: aborted write
    cs_low();
    run_frame(1'b0, 6'd1, 8'h0F, 15, 8'h00, 0, "R4 abort");
    cs_high();
    check_fields("R4 abort");
    wr(6'd1, 8'h3C, "R4 next frame");

    // R5: back to back writes
    cs_low();
    run_frame(1'b0, 6'd1, 8'hC6, 16, 8'h00, 0, "R5 first");
    model_write(6'd1, 8'hC6);
    run_frame(1'b0, 6'd2, 8'h12, 16, 8'h00, 0, "R5 second");
    model_write(6'd2, 8'h12);
    cs_high();
    check_fields("R5 back to back");

    // R7: read locks the window
    cs_low();
    run_frame(1'b1, 6'd2, 8'h00, 16, model_read(6'd2), 1, "R7 read");
    run_frame(1'b0, 6'd1, 8'h33, 16, 8'h00, 2, "R7 write after read");
    cs_high();
    check_fields("R7 ignored");

    // R8: command word
    wr(6'd3, 8'h55, "R8 wrong key");
    wr(6'd3, 8'hAA, "R8 key");
    chk(pwr_mode_o == 2'b00, "R8 power mode", pwr_mode_o, 0);

    // R11: asynchronous reset
    wr(6'd1, 8'h7E, "R11 setup");
    @(negedge clk);
    rst_ni = 1'b0;
    m_a = 8'h85; m_b = 8'h04;
    #2;
    check_fields("R11 async");
    tick(3);
    rst_ni = 1'b1;
    tick(10);
    rd(6'd1, "R11 readback");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule